// File: doc/BRIEF.md
# Snooping Line State Responder

This block answers coherence snoops that arrive from the memory-side bus for a single cache. The snoop arrives with its attribute bits: read, invalidate, exclusive and uncacheable. Alongside it come the status bits of the matching line, which tag lookup has already found, and a flag that says whether a pending writeback holds the same block. From these inputs the block works out the line's new status bits and drives the bus-side shared and memory-inhibit signals. When this cache must source the data, it returns that data after a fixed hit latency.

An owned state is supported: a line can be dirty but not writable. After a non-invalidating read, the line keeps its dirty bit, so the cache stays responsible for the data and does not write it back. The supply decision is taken from the line's status before any invalidation, so a dirty line that is also being invalidated still sources its data. Only one data response can be in flight at a time. While it is pending, the block reports busy and ignores any new snoop.

Top module: `snoop_line_responder`

## Requirements
- R1: After reset, every output is low: busy, update valid, shared, inhibit, protocol error and response valid.
- R2: A snoop marked uncacheable, or a snoop presented while busy is high, has no effect. In the following cycles there is no update, no shared, no inhibit, no error and no response.
- R3: A cacheable snoop to a line whose valid bit is clear produces no update, no shared, no inhibit and no response. The line status is encoded as {valid, writable, dirty}, with valid in bit 2.
- R4: A read without invalidate to a valid line asserts shared. It also reports an update in which the valid and dirty bits are kept and the writable bit (bit 1) is cleared. A dirty, non-writable line therefore stays owned.
- R5: Data is supplied only for a read that finds the line dirty (bit 0). In that case inhibit is asserted and the line data is returned with response valid exactly HIT_LAT cycles after the snoop's clock edge.
- R6: A snoop with invalidate reports an update with all status bits cleared and does not assert shared. If it is also a read to a dirty line, the old data is still supplied.
- R7: A snoop that neither reads nor invalidates a valid line reports an update with its status bits unchanged, and it asserts neither shared nor inhibit.
- R8: A read that matches a pending writeback is answered from the writeback data, with inhibit asserted after HIT_LAT cycles. Shared is asserted only when exclusive is not set, and no line update is reported. A writeback match on a non-read falls through to the line handling.
- R9: A cacheable snoop that has exclusive set but invalidate clear raises the protocol error output.
- R10: Busy rises with a supplying snoop and falls in the cycle the response is delivered. Response valid is a single-cycle pulse.
- R11: Update, shared, inhibit and error are registered. They are high for exactly the one cycle after the snoop's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| snp_valid_i | input | 1 | Snoop present this cycle |
| snp_read_i | input | 1 | Snoop reads the block |
| snp_inval_i | input | 1 | Snoop invalidates the block |
| snp_excl_i | input | 1 | Requester wants exclusive access |
| snp_uncache_i | input | 1 | Uncacheable snoop |
| line_st_i | input | 3 | Looked-up line status {valid, writable, dirty} |
| line_data_i | input | DATA_W | Line data |
| wb_hit_i | input | 1 | A pending writeback matches the block |
| wb_data_i | input | DATA_W | Data of the matching writeback |
| busy_o | output | 1 | A supply response is pending |
| upd_valid_o | output | 1 | Line status update present |
| upd_st_o | output | 3 | New line status {valid, writable, dirty} |
| shared_o | output | 1 | Shared signal to the bus |
| inhibit_o | output | 1 | Memory-inhibit signal to the bus |
| proto_err_o | output | 1 | Exclusive without invalidate seen |
| resp_valid_o | output | 1 | Data response pulse |
| resp_data_o | output | DATA_W | Data response payload |

## Verification
The snoop is sampled on a clock edge, and the update, shared, inhibit and error results are due in the cycle after that edge. The data response is due HIT_LAT edges after the snoop edge. The bench keeps a behavioural reference model that is advanced on each rising edge and follows the same schedule. Every output is compared against the model on each falling edge. The bench also issues back-to-back snoops so that an arrival during busy is covered, and it checks the response payload only in the cycle the model expects the pulse.

// File: rtl/snoop_rsp_pkg.sv
package snoop_rsp_pkg;

    typedef struct packed {
        logic valid;
        logic writable;
        logic dirty;
    } line_st_t;

    typedef struct packed {
        logic read;
        logic inval;
        logic excl;
        logic uncache;
    } snp_cmd_t;

    typedef struct packed {
        logic     upd;
        line_st_t st;
        logic     shared;
        logic     inhibit;
        logic     supply;
        logic     from_wb;
        logic     err;
    } snp_dec_t;

    // Status after the snoop; invalidation is applied last and wins.
    function automatic line_st_t next_line_state(line_st_t cur, snp_cmd_t c);
        line_st_t n;
        n = cur;
        if (c.read && !c.inval)
            n.writable = 1'b0;
        if (c.inval)
            n = '0;
        return n;
    endfunction

endpackage

// File: rtl/snoop_decide.sv
module snoop_decide
    import snoop_rsp_pkg::*;
(
    input  logic     act_i,
    input  snp_cmd_t cmd_i,
    input  line_st_t line_i,
    input  logic     wb_hit_i,
    output snp_dec_t dec_o
);

    always_comb begin
        dec_o = '0;
        if (act_i && !cmd_i.uncache) begin
            dec_o.err = cmd_i.excl && !cmd_i.inval;
            if (wb_hit_i && cmd_i.read) begin
                dec_o.supply  = 1'b1;
                dec_o.from_wb = 1'b1;
                dec_o.inhibit = 1'b1;
                dec_o.shared  = !cmd_i.excl;
            end else if (line_i.valid) begin
                dec_o.upd     = 1'b1;
                dec_o.supply  = line_i.dirty && cmd_i.read;
                dec_o.inhibit = line_i.dirty && cmd_i.read;
                dec_o.shared  = cmd_i.read && !cmd_i.inval;
                dec_o.st      = next_line_state(line_i, cmd_i);
            end
        end
    end

endmodule

// File: rtl/snoop_resp_pipe.sv
module snoop_resp_pipe #(
    parameter int DATA_W  = 32,
    parameter int HIT_LAT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              busy_o,
    output logic              resp_valid_o,
    output logic [DATA_W-1:0] resp_data_o
);

    localparam int CW = (HIT_LAT < 2) ? 1 : $clog2(HIT_LAT);
    localparam logic [CW-1:0] LOAD_VAL = CW'(HIT_LAT - 1);

    logic              pend_q;
    logic [CW-1:0]     cnt_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q       <= 1'b0;
            cnt_q        <= '0;
            data_q       <= '0;
            resp_valid_o <= 1'b0;
        end else begin
            resp_valid_o <= 1'b0;
            if (load_i) begin
                pend_q <= 1'b1;
                cnt_q  <= LOAD_VAL;
                data_q <= data_i;
            end else if (pend_q) begin
                if (cnt_q == '0) begin
                    pend_q       <= 1'b0;
                    resp_valid_o <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    assign busy_o      = pend_q;
    assign resp_data_o = data_q;

    // R10
    single_load_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |-> !pend_q);

    // R10
    resp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid_o |=> !resp_valid_o);

endmodule

// File: rtl/snoop_line_responder.sv
module snoop_line_responder
    import snoop_rsp_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int HIT_LAT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              snp_valid_i,
    input  logic              snp_read_i,
    input  logic              snp_inval_i,
    input  logic              snp_excl_i,
    input  logic              snp_uncache_i,
    input  logic [2:0]        line_st_i,
    input  logic [DATA_W-1:0] line_data_i,
    input  logic              wb_hit_i,
    input  logic [DATA_W-1:0] wb_data_i,
    output logic              busy_o,
    output logic              upd_valid_o,
    output logic [2:0]        upd_st_o,
    output logic              shared_o,
    output logic              inhibit_o,
    output logic              proto_err_o,
    output logic              resp_valid_o,
    output logic [DATA_W-1:0] resp_data_o
);

    snp_cmd_t          cmd;
    snp_dec_t          dec;
    snp_dec_t          dec_q;
    logic              accept;
    logic              busy;
    logic [DATA_W-1:0] sup_data;

    assign cmd    = '{read: snp_read_i, inval: snp_inval_i,
                      excl: snp_excl_i, uncache: snp_uncache_i};
    assign accept = snp_valid_i && !busy;

    snoop_decide u_dec (
        .act_i    (accept),
        .cmd_i    (cmd),
        .line_i   (line_st_t'(line_st_i)),
        .wb_hit_i (wb_hit_i),
        .dec_o    (dec)
    );

    assign sup_data = dec.from_wb ? wb_data_i : line_data_i;

    snoop_resp_pipe #(.DATA_W(DATA_W), .HIT_LAT(HIT_LAT)) u_pipe (
        .clk          (clk),
        .rst          (rst),
        .load_i       (dec.supply),
        .data_i       (sup_data),
        .busy_o       (busy),
        .resp_valid_o (resp_valid_o),
        .resp_data_o  (resp_data_o)
    );

    always_ff @(posedge clk) begin
        if (rst) dec_q <= '0;
        else     dec_q <= dec;
    end

    assign busy_o      = busy;
    assign upd_valid_o = dec_q.upd;
    assign upd_st_o    = dec_q.st;
    assign shared_o    = dec_q.shared;
    assign inhibit_o   = dec_q.inhibit;
    assign proto_err_o = dec_q.err;

    // R4
    shared_drops_write_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_valid_o && shared_o) |-> !upd_st_o[1]);

    // R6
    inval_clears_all_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_valid_o && !upd_st_o[2]) |-> (upd_st_o == 3'b000));

    // R5
    inhibit_busy_chk: assert property (@(posedge clk) disable iff (rst)
        inhibit_o |-> busy_o);

    // R9
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        proto_err_o |-> ($past(snp_excl_i) && !$past(snp_inval_i)));

endmodule

// File: tb/sim_snoop_line_responder.sv
module sim_snoop_line_responder;

    localparam int DW  = 32;
    localparam int LAT = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          v = 0, rd = 0, inv = 0, ex = 0, unc = 0, wbh = 0;
    logic [2:0]    st = 0;
    logic [DW-1:0] ld = 0, wd = 0;
    logic          busy, updv, sh, inh, err, rv;
    logic [2:0]    ust;
    logic [DW-1:0] rdat;

    int    errors = 0;
    int    checks = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    snoop_line_responder #(.DATA_W(DW), .HIT_LAT(LAT)) u0 (
        .clk(clk), .rst(rst), .snp_valid_i(v), .snp_read_i(rd),
        .snp_inval_i(inv), .snp_excl_i(ex), .snp_uncache_i(unc),
        .line_st_i(st), .line_data_i(ld), .wb_hit_i(wbh), .wb_data_i(wd),
        .busy_o(busy), .upd_valid_o(updv), .upd_st_o(ust), .shared_o(sh),
        .inhibit_o(inh), .proto_err_o(err), .resp_valid_o(rv),
        .resp_data_o(rdat)
    );

    // Behavioural reference model
    bit          m_busy, e_upd, e_sh, e_inh, e_err, e_rv;
    int          m_left;
    bit [2:0]    e_st;
    bit [DW-1:0] m_data, e_rd;

    always @(posedge clk) begin
        bit acc;
        if (rst) begin
            m_busy = 0; m_left = 0; e_upd = 0; e_sh = 0; e_inh = 0;
            e_err = 0; e_rv = 0; e_st = 0;
        end else begin
            acc  = v && !m_busy && !unc;
            e_rv = 0;
            if (m_busy) begin
                m_left--;
                if (m_left == 0) begin e_rv = 1; e_rd = m_data; m_busy = 0; end
            end
            e_upd = 0; e_sh = 0; e_inh = 0; e_err = 0; e_st = 0;
            if (acc) begin
                e_err = ex && !inv;
                if (wbh && rd) begin
                    e_inh = 1; e_sh = !ex;
                    m_busy = 1; m_left = LAT; m_data = wd;
                end else if (st[2]) begin
                    e_upd = 1;
                    e_sh  = rd && !inv;
                    e_st  = inv ? 3'b000 : (rd ? {st[2], 1'b0, st[0]} : st);
                    if (rd && st[0]) begin
                        e_inh = 1; m_busy = 1; m_left = LAT; m_data = ld;
                    end
                end
            end
        end
    end

    task automatic chk(input string what, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            chk("busy (R10)", DW'(busy), DW'(m_busy));
            chk("upd_valid (R11)", DW'(updv), DW'(e_upd));
            if (e_upd) chk("upd_st", DW'(ust), DW'(e_st));
            chk("shared", DW'(sh), DW'(e_sh));
            chk("inhibit (R5)", DW'(inh), DW'(e_inh));
            chk("proto_err (R9)", DW'(err), DW'(e_err));
            chk("resp_valid (R10)", DW'(rv), DW'(e_rv));
            if (e_rv) chk("resp_data", rdat, e_rd);
        end
    end

    task automatic snp(input logic r, input logic i, input logic e,
                       input logic u, input logic [2:0] s,
                       input logic [DW-1:0] d, input logic wh,
                       input logic [DW-1:0] w);
        v = 1; rd = r; inv = i; ex = e; unc = u; st = s; ld = d; wbh = wh; wd = w;
        @(negedge clk);
        v = 0;
    endtask

    task automatic idle(input int n);
        v = 0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        cur_req = "R1";
        chk("reset outputs", DW'({busy, updv, sh, inh, err, rv}), '0);

        cur_req = "R3"; snp(1, 0, 0, 0, 3'b011, 32'h11, 0, 0); idle(4);
        cur_req = "R4"; snp(1, 0, 0, 0, 3'b110, 32'h22, 0, 0); idle(4);
        cur_req = "R5"; snp(1, 0, 0, 0, 3'b111, 32'hA5A5_0001, 0, 0); idle(4);
        cur_req = "R4"; snp(1, 0, 0, 0, 3'b101, 32'h0BED_0002, 0, 0); idle(4);
        cur_req = "R10";
        snp(1, 0, 0, 0, 3'b111, 32'hCAFE_0003, 0, 0);
        snp(1, 1, 1, 0, 3'b111, 32'hDEAD_0004, 0, 0);
        idle(4);
        cur_req = "R6"; snp(1, 1, 1, 0, 3'b111, 32'h6060_0005, 0, 0); idle(4);
        cur_req = "R6"; snp(0, 1, 0, 0, 3'b110, 32'h66, 0, 0); idle(4);
        cur_req = "R7"; snp(0, 0, 0, 0, 3'b101, 32'h77, 0, 0); idle(4);
        cur_req = "R8"; snp(1, 0, 0, 0, 3'b000, 32'h0, 1, 32'h8888_0001); idle(4);
        cur_req = "R8"; snp(1, 1, 1, 0, 3'b110, 32'h1, 1, 32'h8888_0002); idle(4);
        cur_req = "R8"; snp(0, 1, 0, 0, 3'b111, 32'h2, 1, 32'h8888_0003); idle(4);
        cur_req = "R9"; snp(1, 0, 1, 0, 3'b110, 32'h99, 0, 0); idle(4);
        cur_req = "R2"; snp(1, 1, 1, 1, 3'b111, 32'h2222, 1, 32'h3); idle(4);
        cur_req = "R11";
        for (int k = 0; k < 400; k++) begin
            snp($urandom_range(0, 1), $urandom_range(0, 1),
                $urandom_range(0, 1), ($urandom_range(0, 7) == 0),
                3'($urandom_range(0, 7)), $urandom, ($urandom_range(0, 3) == 0),
                $urandom);
            if ($urandom_range(0, 2) == 0) idle(1);
        end
        idle(6);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule